// File: doc/BRIEF.md
# Loadable Four-Channel Clock Divider Bank

This block derives four divided clocks from one fast reference clock. Software sets each channel's ratio through two 32-bit registers. The control word at byte offset 0 holds one ratio field and one load bit for each channel. The secondary word at byte offset 4 carries, in bit 10, an active-low reset for the whole divider bank.

Writing a ratio field changes nothing on its own. The new value is taken only when that channel's load bit goes from 0 to 1. The channel then holds the value as pending and switches to it at the end of the output period already in progress. Channel 0 reads its field through a scrambled code table. Channels 1 to 3 use the field directly as the divide ratio.

The register port is synchronous to the reference clock. The usual software sequence is:
1. Set bit 10 of the secondary word.
2. Write the new fields with the load bits clear.
3. Write the same value with the wanted load bits set, and hold it for at least 250 ns.
4. Clear the load bits again.

Top module: `div_bank`

## Requirements
- R1: Register file: a write with `bus_addr`=0 stores the 32-bit control word and a write with `bus_addr`=4 stores the 32-bit secondary word. Reading address 0 or 4 returns the stored word, and reading any other address returns 0. Both words reset to 0.
- R2: While bit 10 of the secondary word is 0 (including after reset), all four outputs stay low and each channel returns to its default ratio: 2 for channel 0 and 1 for channels 1 to 3. When the bit is 1, the channels run.
- R3: Channel k (k = 0..3) has its 6-bit ratio field at control-word bits [6+7k:1+7k] and its load bit at bit 7+7k. In the control word, channel 0 uses bits 6:1 with load at 7, channel 1 uses bits 13:8 with load at 14, channel 2 uses bits 20:15 with load at 21, and channel 3 uses bits 27:22 with load at 28.
- R4: A channel changes ratio only after its load bit goes from 0 to 1. Writing a field with the load bit clear, or while the load bit is already 1, leaves the output period unchanged.
- R5: A loaded ratio takes effect at the next boundary of the output period. The period in progress runs to its full old length, and the next period has the new length, so no short pulse is produced.
- R6: Channels 1 to 3 divide by the field value. Every value from 1 to 63 is legal.
- R7: Channel 0 decodes its field as follows. Codes 1 and 2 give ratios 2 and 1, codes 5 and 6 give 6 and 5, and codes 9 and 10 give 10 and 9. Codes 3, 4, 7 and 8 give the same number as the code.
- R8: A load that carries an illegal value keeps the previous ratio. The illegal values are 0 for every channel and 11 to 63 for channel 0.
- R9: At ratio N, the output period is N reference periods and the high time is N/2 reference periods. Odd N uses the falling reference edge to get this half period. N = 1 passes the reference clock through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; also clocks the register port |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Byte address (0 = control, 4 = secondary) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| div_clk | output | 4 | Divided clock outputs, one per channel |

## Verification
A wrong active ratio shows at a channel's output as a wrong rising-edge spacing within two output periods. A wrong odd/even handling shows as a wrong high time in the first full period. A pending ratio applied too early shows as a shortened period on the edge right after the load. A ratio that was never applied shows as the old period persisting well after the next boundary. A lost or stray run state shows as edges during the hold, or as a non-default period right after it is released.

// File: rtl/div_pkg.sv
`timescale 1ns/1ps
// div_pkg: shared constants and the channel-0 code decoder for the divider bank.
// Assumes a 32-bit register word and 6-bit ratio fields packed 7 bits apart.
package div_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int FLD_W    = 6;
    localparam int NUM_CH   = 4;
    localparam int CH_PITCH = FLD_W + 1;       // field plus its load bit
    localparam int FLD_BASE = 1;               // first field starts at bit 1
    localparam int RUN_BIT  = 10;              // active-low reset in secondary word
    localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_AUX  = 3'd4;

    // Scrambled code to ratio; 0 means the code is not supported.
    function automatic logic [FLD_W-1:0] code_to_ratio(input logic [FLD_W-1:0] code);
        logic [FLD_W-1:0] r;
        case (code)
            6'd1:    r = 6'd2;
            6'd2:    r = 6'd1;
            6'd3:    r = 6'd3;
            6'd4:    r = 6'd4;
            6'd5:    r = 6'd6;
            6'd6:    r = 6'd5;
            6'd7:    r = 6'd7;
            6'd8:    r = 6'd8;
            6'd9:    r = 6'd10;
            6'd10:   r = 6'd9;
            default: r = 6'd0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/div_regs.sv
`timescale 1ns/1ps
// div_regs: the two-word register file of the divider bank.
// Assumes a single-cycle write strobe synchronous to the reference clock;
// reads are combinational and unmapped addresses read as zero.
module div_regs
    import div_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] ctrl_word,
    output logic              run
);
    logic [DATA_W-1:0] aux_word;

    // Store whichever word the write address selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_word <= '0;
            aux_word  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFS_CTRL) ctrl_word <= bus_wdata;
            if (bus_addr == OFS_AUX)  aux_word  <= bus_wdata;
        end
    end

    // Read mux over the two mapped words.
    always_comb begin
        if (bus_addr == OFS_CTRL)     bus_rdata = ctrl_word;
        else if (bus_addr == OFS_AUX) bus_rdata = aux_word;
        else                          bus_rdata = '0;
    end

    assign run = aux_word[RUN_BIT];
endmodule

// File: rtl/div_chan.sv
`timescale 1ns/1ps
// div_chan: one integer clock divider with a shadow ratio.
// A 0->1 edge on load_lvl captures the decoded field as pending. The pending
// ratio is applied when the counter wraps, so periods are never cut short.
// Odd ratios AND the counter phase with a half-cycle delayed copy made on
// the falling reference edge; ratio 1 gates the reference clock through.
// Assumes field and load_lvl are synchronous to clk.
module div_chan
    import div_pkg::*;
#(
    parameter bit CODED     = 1'b0,  // 1: field goes through code_to_ratio
    parameter int DEF_RATIO = 1      // ratio while the bank is held
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [FLD_W-1:0] field,
    input  logic             load_lvl,
    output logic             clk_o,
    output logic [FLD_W-1:0] ratio_o,
    output logic             pend_o
);
    localparam logic [FLD_W-1:0] DEF = FLD_W'(DEF_RATIO);

    logic             ld_q, pend_vld, p_q, n_q, nxt_p, rise, wrap;
    logic [FLD_W-1:0] dec, pend_r, ratio, cnt, nxt_cnt, nxt_ratio;
    logic [FLD_W:0]   half;

    // Decode the field for this channel variant.
    generate
        if (CODED) begin : g_coded
            assign dec = code_to_ratio(field);
        end else begin : g_plain
            assign dec = field;
        end
    endgenerate

    // Next-state terms for counter, ratio and the phase bit.
    always_comb begin
        rise      = load_lvl & ~ld_q;
        wrap      = (cnt == ratio - 1'b1);
        nxt_ratio = (wrap && pend_vld) ? pend_r : ratio;
        nxt_cnt   = wrap ? '0 : cnt + 1'b1;
        half      = ({1'b0, nxt_ratio} + 1'b1) >> 1;
        nxt_p     = ({1'b0, nxt_cnt} < half);
    end

    // Rising-edge state: load edge detect, pending capture, counter and phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_q     <= 1'b0;
            pend_vld <= 1'b0;
            pend_r   <= DEF;
            ratio    <= DEF;
            cnt      <= '0;
            p_q      <= 1'b0;
        end else if (!run) begin
            ld_q     <= load_lvl;
            pend_vld <= 1'b0;
            ratio    <= DEF;
            cnt      <= '0;
            p_q      <= 1'b0;
        end else begin
            ld_q  <= load_lvl;
            ratio <= nxt_ratio;
            cnt   <= nxt_cnt;
            p_q   <= nxt_p;
            if (wrap) pend_vld <= 1'b0;
            if (rise && dec != '0) begin
                pend_r   <= dec;
                pend_vld <= 1'b1;
            end
        end
    end

    // Half-cycle delayed phase for odd ratios.
    always_ff @(negedge clk) begin
        if (!rst_n || !run) n_q <= 1'b0;
        else                n_q <= p_q;
    end

    // Output select by ratio class.
    always_comb begin
        if (ratio == 6'd1)  clk_o = clk & p_q;
        else if (ratio[0])  clk_o = p_q & n_q;
        else                clk_o = p_q;
    end

    assign ratio_o = ratio;
    assign pend_o  = pend_vld;
endmodule

// File: rtl/div_bank.sv
`timescale 1ns/1ps
// div_bank: register file plus four loadable dividers on one reference clock.
// Assumes the register port is synchronous to clk. Channel 0 uses the
// scrambled code table; the others divide by the raw field value.
module div_bank
    import div_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] div_clk
);
    logic [DATA_W-1:0]             ctrl_word;
    logic                          run;
    logic [NUM_CH-1:0][FLD_W-1:0]  act_ratio;
    logic [NUM_CH-1:0]             pend_vld;

    div_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ctrl_word (ctrl_word),
        .run       (run)
    );

    // One divider per channel; field and load bit positions follow the pitch.
    generate
        for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
            localparam int LSB = FLD_BASE + k * CH_PITCH;
            div_chan #(
                .CODED     (k == 0),
                .DEF_RATIO ((k == 0) ? 2 : 1)
            ) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .run      (run),
                .field    (ctrl_word[LSB +: FLD_W]),
                .load_lvl (ctrl_word[LSB + FLD_W]),
                .clk_o    (div_clk[k]),
                .ratio_o  (act_ratio[k]),
                .pend_o   (pend_vld[k])
            );
        end
    endgenerate
endmodule

// File: rtl/div_bank_chk.sv
`timescale 1ns/1ps
// div_bank_chk: protocol and state properties of the divider bank, bound
// to div_bank. Assumes the same clock and reset as the design.
module div_bank_chk
    import div_pkg::*;
(
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bus_wr,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic [DATA_W-1:0]            bus_wdata,
    input logic [DATA_W-1:0]            ctrl_word,
    input logic                         run,
    input logic [NUM_CH-1:0]            div_clk,
    input logic [NUM_CH-1:0][FLD_W-1:0] act_ratio,
    input logic [NUM_CH-1:0]            pend_vld
);
    // R1: a control-word write is stored the next cycle.
    p_ctrl_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CTRL) |=> (ctrl_word == $past(bus_wdata)));

    // R2: a held bank drives every output low.
    p_hold_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (div_clk == '0));

    // R7: channel 0 only ever runs at a ratio from its table.
    p_ch0_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_ratio[0] != '0) && (act_ratio[0] <= 6'd10));

    generate
        for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
            // R4: without a pending load the active ratio holds.
            p_no_load_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (run && !pend_vld[k]) |=> (!run || act_ratio[k] == $past(act_ratio[k])));
            // R8: an illegal value never becomes the active ratio.
            p_ratio_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
                act_ratio[k] != '0);
        end
    endgenerate
endmodule

bind div_bank div_bank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctrl_word (ctrl_word),
    .run       (run),
    .div_clk   (div_clk),
    .act_ratio (act_ratio),
    .pend_vld  (pend_vld)
);

// File: tb/tb_div_bank.sv
`timescale 1ns/1ps
// tb_div_bank: sweeps every plain ratio and every channel-0 code and
// measures output periods and high times against arithmetic expectations.
module tb_div_bank;
    localparam real TCLK = 8.0;
    localparam logic [31:0] LD0 = 32'h1 << 7;
    localparam logic [31:0] LD1 = 32'h1 << 14;
    localparam logic [31:0] LD2 = 32'h1 << 21;
    localparam logic [31:0] LD3 = 32'h1 << 28;
    localparam logic [31:0] RUNW = 32'h1 << 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  div_clk;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] cur = '0;

    always #(TCLK / 2.0) clk = ~clk;

    div_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .div_clk(div_clk)
    );

    // Per-channel edge monitors: last period, last high time, rise count.
    for (genvar g = 0; g < 4; g++) begin : g_mon
        realtime t_rise = 0.0;
        real     per = 0.0;
        real     hi = 0.0;
        int      nrise = 0;
        always @(posedge div_clk[g]) begin
            per   = $realtime - t_rise;
            t_rise = $realtime;
            nrise++;
        end
        always @(negedge div_clk[g]) hi = $realtime - t_rise;
    end

    function automatic real get_per(input int ch);
        case (ch)
            0: return g_mon[0].per;
            1: return g_mon[1].per;
            2: return g_mon[2].per;
            default: return g_mon[3].per;
        endcase
    endfunction
    function automatic real get_hi(input int ch);
        case (ch)
            0: return g_mon[0].hi;
            1: return g_mon[1].hi;
            2: return g_mon[2].hi;
            default: return g_mon[3].hi;
        endcase
    endfunction
    function automatic int get_n(input int ch);
        case (ch)
            0: return g_mon[0].nrise;
            1: return g_mon[1].nrise;
            2: return g_mon[2].nrise;
            default: return g_mon[3].nrise;
        endcase
    endfunction

    // Field packing per R3: channel k field at bit 1+7k.
    function automatic logic [31:0] mkw(input int c0, input int c1, input int c2, input int c3);
        return (32'(c0) << 1) | (32'(c1) << 8) | (32'(c2) << 15) | (32'(c3) << 22);
    endfunction

    // Channel-0 expected ratio per R7, computed by pair swaps.
    function automatic int code_exp(input int c);
        if (c == 1 || c == 2) return 3 - c;
        if (c == 5 || c == 6) return 11 - c;
        if (c == 9 || c == 10) return 19 - c;
        return c;
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic check_r(input bit ok, input string req, input string what,
                           input real act, input real exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
        end
    endtask

    function automatic bit near(input real a, input real b);
        return (a - b < 0.01) && (b - a < 0.01);
    endfunction

    // Period and high time of a channel against ratio n (R9).
    task automatic chk_clk(input int ch, input int n, input string req);
        real p, h;
        p = get_per(ch);
        h = get_hi(ch);
        check_r(near(p, TCLK * n), req, $sformatf("ch%0d period", ch), p, TCLK * n);
        check_r(near(h, TCLK * n / 2.0), req, $sformatf("ch%0d high time", ch), h, TCLK * n / 2.0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Software load sequence: value, value+load held 250 ns, value.
    task automatic load_seq(input logic [31:0] w, input logic [31:0] ld);
        cur = w;
        wr(3'd0, w);
        wr(3'd0, w | ld);
        repeat (32) @(negedge clk);
        wr(3'd0, w);
        repeat (300) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int n0;
        repeat (5) @(negedge clk);
        // R1 / R2: reset state.
        rd(3'd0, d); check_r(d == 0, "R1", "ctrl after reset", real'(d), 0.0);
        rd(3'd4, d); check_r(d == 0, "R1", "aux after reset", real'(d), 0.0);
        check_r(div_clk == 0, "R2", "outputs in reset", real'(div_clk), 0.0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check_r(div_clk == 0, "R2", "outputs while held", real'(div_clk), 0.0);

        // R2: release hold, defaults 2/1/1/1.
        wr(3'd4, RUNW);
        rd(3'd4, d); check_r(d == RUNW, "R1", "aux readback", real'(d), real'(RUNW));
        repeat (40) @(negedge clk);
        chk_clk(0, 2, "R2"); chk_clk(1, 1, "R2"); chk_clk(2, 1, "R2"); chk_clk(3, 1, "R2");

        // R6 / R9 / R3: sweep every plain ratio on channels 1..3.
        for (int r = 1; r <= 63; r++) begin
            load_seq(mkw(1, r, 64 - r, ((r * 5) % 63) + 1), LD1 | LD2 | LD3);
            chk_clk(1, r, "R6");
            chk_clk(2, 64 - r, "R6");
            chk_clk(3, ((r * 5) % 63) + 1, "R9");
        end
        rd(3'd0, d); check_r(d == cur, "R1", "ctrl readback", real'(d), real'(cur));

        // R7: every supported channel-0 code.
        for (int c = 1; c <= 10; c++) begin
            load_seq(mkw(c, 3, 4, 5), LD0 | LD1 | LD2 | LD3);
            chk_clk(0, code_exp(c), "R7");
        end
        load_seq(mkw(4, 5, 6, 7), LD0 | LD1 | LD2 | LD3);
        chk_clk(0, 4, "R3"); chk_clk(1, 5, "R3"); chk_clk(2, 6, "R3"); chk_clk(3, 7, "R3");

        // R8: illegal loads keep the previous ratio.
        load_seq(mkw(0, 0, 6, 7), LD0 | LD1);
        chk_clk(0, 4, "R8"); chk_clk(1, 5, "R8");
        load_seq(mkw(11, 5, 6, 7), LD0);
        chk_clk(0, 4, "R8");
        load_seq(mkw(63, 5, 6, 7), LD0);
        chk_clk(0, 4, "R8");

        // R4: field written without a load edge has no effect.
        cur = mkw(4, 5, 20, 7);
        wr(3'd0, cur);
        repeat (300) @(negedge clk);
        chk_clk(2, 6, "R4");
        rd(3'd0, d); check_r(d == cur, "R1", "unloaded field readback", real'(d), real'(cur));
        // R4: field changed while load bit stays high has no effect.
        wr(3'd0, mkw(4, 5, 6, 7) | LD2);
        repeat (20) @(negedge clk);
        wr(3'd0, mkw(4, 5, 9, 7) | LD2);
        repeat (300) @(negedge clk);
        chk_clk(2, 6, "R4");
        wr(3'd0, mkw(4, 5, 9, 7));

        // R5: old period completes in full, then the new ratio.
        load_seq(mkw(4, 40, 6, 7), LD1);
        chk_clk(1, 40, "R5");
        cur = mkw(4, 2, 6, 7);
        wr(3'd0, cur);
        n0 = get_n(1);
        while (get_n(1) == n0) @(negedge clk);
        wr(3'd0, cur | LD1);
        n0 = get_n(1);
        while (get_n(1) == n0) @(negedge clk);
        check_r(near(get_per(1), 320.0), "R5", "period ending at switch", get_per(1), 320.0);
        n0 = get_n(1);
        while (get_n(1) == n0) @(negedge clk);
        check_r(near(get_per(1), 16.0), "R5", "first new period", get_per(1), 16.0);
        wr(3'd0, cur);

        // R2: hold freezes outputs low, release restores defaults.
        wr(3'd4, 32'h0);
        repeat (5) @(negedge clk);
        n0 = get_n(0) + get_n(1) + get_n(2) + get_n(3);
        repeat (100) @(negedge clk);
        check_r(get_n(0) + get_n(1) + get_n(2) + get_n(3) == n0, "R2", "edges while held",
                real'(get_n(0) + get_n(1) + get_n(2) + get_n(3)), real'(n0));
        check_r(div_clk == 0, "R2", "outputs low while held", real'(div_clk), 0.0);
        wr(3'd4, RUNW);
        repeat (40) @(negedge clk);
        chk_clk(0, 2, "R2"); chk_clk(1, 1, "R2"); chk_clk(2, 1, "R2"); chk_clk(3, 1, "R2");
        rd(3'd2, d); check_r(d == 0, "R1", "unmapped read", real'(d), 0.0);

        finish_run();
    end
endmodule